// File: doc/BRIEF.md
# Stereo Serial Sample Receive Port

This block is the digital receive side of a two-channel serial converter link. Each channel has its own serial data line and its own latch strobe, and both channels share one bit clock. On every rising clock edge each channel shifts its data bit into a private shift register, which therefore always holds the most recent bits. When a channel's strobe goes from high to low, the newest complete word in that channel's shift register is copied into a parallel holding register. That register feeds the converter, and the channel raises a one-cycle update pulse.

Words are 18-bit two's complement and arrive MSB first. A sender may put any number of padding bits ahead of a word, because only the final 18 bits before the strobe edge count. The two strobes may be tied together so that both channels update at once. The two data lines may be tied together so that a single stream feeds both channels, and then the strobe timing alone decides which word goes to which channel. Each channel also offers its held word in offset binary form.

Strobe edges are found by a three-state machine per channel, with these states. LS_WAIT_HIGH means the strobe was last seen low with no transfer pending; it is the reset state. LS_ARMED means the strobe was last seen high. LS_FIRED means a transfer has just taken place. The transitions are as follows. WAIT_HIGH goes to ARMED when the strobe is sampled high. ARMED stays in ARMED while the strobe is high. ARMED goes to FIRED when the strobe is sampled low, and that edge loads the holding register. FIRED goes to ARMED when the strobe is sampled high, and to WAIT_HIGH when it is sampled low.

Top module: `sdac_rx_port`

## Requirements
- R1: On each rising edge of `clk`, each channel shifts the level of its data input into the LSB end of its own 18-bit shift register. The first bit received therefore ends up as the MSB of a word.
- R2: A transfer loads the holding register with the 18 bits sampled on the 18 clock edges immediately before the edge that sees the strobe low. Any bits received earlier are discarded.
- R3: A channel's held word does not change unless that channel's own strobe produces a transfer. A strobe edge on the other channel leaves it unchanged.
- R4: A transfer happens at the first rising edge that samples the strobe low after an edge that sampled it high. The bit sampled on that same edge is not part of the word. A strobe that stays high, or that rises, causes no transfer.
- R5: The channel's update output is high for exactly the one cycle in which the new word first appears on its word output, and is low at all other times.
- R6: When both strobes carry the same waveform, both channels transfer on the same clock edge.
- R7: When both data inputs carry the same stream, each channel captures the 18 bits that came before its own strobe edge.
- R8: Words can be sent back to back every 18 clocks with no gap between them, with the strobe low for one cycle at the first bit of the following word. Every such word is captured. This amply covers a 352.8 kHz word rate.
- R9: Each offset-binary output equals that channel's held word with its MSB (bit 17) inverted.
- R10: Reset (active-low `rst_n`) clears both shift registers and both held words to zero and drives both update outputs low. A latch after fewer than 18 bits since reset therefore yields those bits with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_l | input | 1 | Serial data, left channel |
| sdata_r | input | 1 | Serial data, right channel |
| strobe_l | input | 1 | Latch strobe, left channel (falling edge transfers) |
| strobe_r | input | 1 | Latch strobe, right channel (falling edge transfers) |
| word_l | output | 18 | Held left word, two's complement |
| word_r | output | 18 | Held right word, two's complement |
| word_l_ob | output | 18 | Held left word, offset binary |
| word_r_ob | output | 18 | Held right word, offset binary |
| upd_l | output | 1 | One-cycle pulse when word_l is loaded |
| upd_r | output | 1 | One-cycle pulse when word_r is loaded |

## Verification
The hardest case to reach from the ports is the tightest one. Here a strobe falls on the very edge that shifts in the first bit of the next word, so the word boundary and the transfer share a single clock edge. A one-bit slip in either the shift or the edge detection would then go unnoticed in looser traffic. The stimulus sends a continuous back-to-back stream in which each strobe is low for a single cycle at each word boundary. Random words with random padding are sent with the data lines tied and with the strobes tied, which shows that channel separation depends only on strobe timing. A few bits sent directly after reset show that the cleared register supplies the zeros above them.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int unsigned SDAC_NUM_CH = 2;

    typedef enum logic [1:0] {
        LS_WAIT_HIGH = 2'd0,
        LS_ARMED     = 2'd1,
        LS_FIRED     = 2'd2
    } latch_state_e;
endpackage

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int unsigned WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [WORD_W-1:0] q
);
    // Newest bit enters at the LSB; the oldest of the window sits at the MSB.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= {q[WORD_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/sdac_latch_fsm.sv
module sdac_latch_fsm
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic load,
    output logic upd
);
    latch_state_e state_q;
    latch_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_WAIT_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            LS_WAIT_HIGH: begin
                state_d = strobe ? LS_ARMED : LS_WAIT_HIGH;
            end
            LS_ARMED: begin
                if (!strobe) begin
                    state_d = LS_FIRED;
                    load    = 1'b1;
                end
            end
            LS_FIRED: begin
                state_d = strobe ? LS_ARMED : LS_WAIT_HIGH;
            end
            default: begin
                state_d = LS_WAIT_HIGH;
            end
        endcase
    end

    assign upd = (state_q == LS_FIRED);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd); // R5

    AST_LOAD_THEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> upd); // R5
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
    parameter int unsigned WORD_W     = 18,
    parameter bit          OFFSET_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic [WORD_W-1:0] dout_ob
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

    generate
        if (OFFSET_OUT) begin : g_ob
            assign dout_ob = {~dout[WORD_W-1], dout[WORD_W-2:0]};
        end else begin : g_no_ob
            assign dout_ob = '0;
        end
    endgenerate

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout)); // R3
endmodule

// File: rtl/sdac_rx_port.sv
module sdac_rx_port
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W     = 18,
    parameter bit          OFFSET_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_l,
    input  logic              sdata_r,
    input  logic              strobe_l,
    input  logic              strobe_r,
    output logic [WORD_W-1:0] word_l,
    output logic [WORD_W-1:0] word_r,
    output logic [WORD_W-1:0] word_l_ob,
    output logic [WORD_W-1:0] word_r_ob,
    output logic              upd_l,
    output logic              upd_r
);
    localparam int unsigned CH = SDAC_NUM_CH;

    logic [CH-1:0]     sd_in;
    logic [CH-1:0]     st_in;
    logic [CH-1:0]     ld;
    logic [CH-1:0]     up;
    logic [WORD_W-1:0] shf  [CH];
    logic [WORD_W-1:0] held [CH];
    logic [WORD_W-1:0] heldo[CH];

    assign sd_in = {sdata_r, sdata_l};
    assign st_in = {strobe_r, strobe_l};

    generate
        for (genvar c = 0; c < CH; c++) begin : g_ch
            sdac_shift #(.WORD_W(WORD_W)) u_shift (
                .clk    (clk),
                .rst_n  (rst_n),
                .bit_in (sd_in[c]),
                .q      (shf[c])
            );

            sdac_latch_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (st_in[c]),
                .load   (ld[c]),
                .upd    (up[c])
            );

            sdac_hold #(.WORD_W(WORD_W), .OFFSET_OUT(OFFSET_OUT)) u_hold (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (ld[c]),
                .din     (shf[c]),
                .dout    (held[c]),
                .dout_ob (heldo[c])
            );
        end
    endgenerate

    assign word_l    = held[0];
    assign word_r    = held[1];
    assign word_l_ob = heldo[0];
    assign word_r_ob = heldo[1];
    assign upd_l     = up[0];
    assign upd_r     = up[1];

    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        upd_l |-> (word_l == $past(shf[0]))); // R2

    AST_FALL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_l |-> (!$past(strobe_l) && $past(strobe_l, 2))); // R4

    AST_TIED_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_l && ($past(strobe_l) == $past(strobe_r))
               && ($past(strobe_l, 2) == $past(strobe_r, 2))) |-> upd_r); // R6
endmodule

// File: tb/tb_sdac_rx_port.sv
module tb_sdac_rx_port;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_l = 1'b0, sd_r = 1'b0, st_l = 1'b0, st_r = 1'b0;
    logic [W-1:0] wl, wr, obl, obr;
    logic ul, ur;
    logic [W-1:0] exp_l = '0, exp_r = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdac_rx_port dut (
        .clk(clk), .rst_n(rst_n),
        .sdata_l(sd_l), .sdata_r(sd_r),
        .strobe_l(st_l), .strobe_r(st_r),
        .word_l(wl), .word_r(wr),
        .word_l_ob(obl), .word_r_ob(obr),
        .upd_l(ul), .upd_r(ur)
    );

    function automatic logic [W-1:0] to_ob(input logic [W-1:0] v);
        return {~v[W-1], v[W-2:0]};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Drive one bit per cycle away from the sampling edge.
    task automatic tick(input logic dl, input logic dr, input logic sl, input logic sr);
        @(negedge clk);
        sd_l = dl; sd_r = dr; st_l = sl; st_r = sr;
        @(posedge clk);
    endtask

    task automatic xfer(input logic [W-1:0] a, input logic [W-1:0] b, input int pad,
                        input bit tie, input bit do_l, input bit do_r);
        logic j;
        for (int p = 0; p < pad; p++) begin
            j = 1'($urandom);
            tick(j, tie ? j : 1'($urandom), do_l, do_r);
        end
        for (int i = W - 1; i >= 0; i--) tick(a[i], tie ? a[i] : b[i], do_l, do_r);
        #2;
        chk("R4 no pulse while strobe high", {17'b0, ul | ur}, '0);
        chk("R3 left held before edge", wl, exp_l);
        chk("R3 right held before edge", wr, exp_r);
        j = 1'($urandom);
        tick(j, tie ? j : ~j, 1'b0, 1'b0);
        #2;
        if (do_l) exp_l = a;
        if (do_r) exp_r = tie ? a : b;
        chk(do_l ? "R2 left word" : "R3 left untouched", wl, exp_l);
        chk(do_r ? "R2 right word" : "R3 right untouched", wr, exp_r);
        chk("R5 left pulse", {17'b0, ul}, {17'b0, do_l});
        chk("R5 right pulse", {17'b0, ur}, {17'b0, do_r});
        chk("R9 left offset binary", obl, to_ob(exp_l));
        chk("R9 right offset binary", obr, to_ob(exp_r));
        tick(1'($urandom), 1'($urandom), 1'b0, 1'b0);
        #2;
        chk("R5 pulse ends", {17'b0, ul | ur}, '0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [W-1:0] sl_w [6];
        logic [W-1:0] sr_w [6];
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #2;
        chk("R10 reset left word", wl, '0);
        chk("R10 reset right word", wr, '0);
        chk("R10 reset pulses", {17'b0, ul | ur}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R10: five bits after reset land above cleared zeros.
        tick(1, 0, 1, 0); tick(0, 0, 1, 0); tick(1, 0, 1, 0);
        tick(1, 0, 1, 0); tick(0, 0, 1, 0);
        tick(1, 1, 0, 0);
        #2;
        exp_l = 18'h00016;
        chk("R10 partial word after reset", wl, exp_l);
        chk("R1 right never latched", wr, '0);

        // Directed extremes, MSB first (R1), tied strobes (R6).
        xfer(18'h20000, 18'h1FFFF, 0, 1'b0, 1'b1, 1'b1);
        chk("R6 both updated same edge", {17'b0, ul}, {17'b0, ur});
        xfer(18'h00001, 18'h3FFFF, 7, 1'b0, 1'b1, 1'b1);
        // R7: tied data, channels separated by strobe timing.
        xfer(18'h2A5A5, 18'h0, 3, 1'b1, 1'b1, 1'b0);
        xfer(18'h15A5A, 18'h0, 5, 1'b1, 1'b0, 1'b1);
        chk("R7 left kept first stream word", wl, 18'h2A5A5);
        chk("R7 right got later stream word", wr, 18'h15A5A);

        // Random traffic with padding (R2, R3).
        for (int k = 0; k < 24; k++) begin
            int m;
            m = int'($urandom_range(1, 3));
            xfer(18'($urandom), 18'($urandom), int'($urandom_range(0, 20)),
                 1'($urandom), m[0], m[1]);
        end

        // R8: back-to-back words, strobe low one cycle at each boundary.
        for (int j = 0; j < 6; j++) begin
            sl_w[j] = 18'($urandom);
            sr_w[j] = 18'($urandom);
        end
        for (int j = 0; j < 6; j++) begin
            for (int i = W - 1; i >= 0; i--) begin
                tick(sl_w[j][i], sr_w[j][i], !(j > 0 && i == W - 1), !(j > 0 && i == W - 1));
                if (j > 0 && i == W - 1) begin
                    #2;
                    chk("R8 stream left word", wl, sl_w[j-1]);
                    chk("R8 stream right word", wr, sr_w[j-1]);
                    chk("R8 stream pulse", {17'b0, ul & ur}, 18'd1);
                end
            end
        end
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        #2;
        chk("R8 last stream left word", wl, sl_w[5]);
        chk("R8 last stream right word", wr, sr_w[5]);

        finish_up();
    end
endmodule